// File: doc/BRIEF.md
# Load-Use Stall Detector

This block is the decode-stage interlock of a five-stage in-order RISC pipeline. It looks at the instruction sitting in the execute stage and at the one being decoded. If the execute-stage instruction is a load and its destination register is one of the decoder's two source registers, the loaded value does not exist yet, and forwarding cannot supply it in time. For that one case the block freezes the front of the pipeline for a single cycle and sends an empty slot downstream.

The block is purely combinational. Its three outputs drive three places. The program-counter write enable and the fetch/decode register write enable hold the fetched and decoded instructions in place. The bubble signal zeroes the control fields loaded into the decode/execute register. One cycle later the load has moved into the memory stage and the condition clears by itself. The value then reaches the held consumer through the usual forwarding path from the memory/writeback register. Every other producer-consumer dependence is left to forwarding and never causes a stall.

Top module: `load_use_stall`

## Requirements
- R1: When `ex_is_load` is 0, no stall occurs whatever the register fields hold: `pc_write_en`=1, `fd_write_en`=1, `ex_bubble`=0. This includes arithmetic producers whose second field matches a source of the decoder.
- R2: When `ex_is_load` is 1 and `ex_dest` equals `dec_src_a`, a stall is signalled.
- R3: When `ex_is_load` is 1 and `ex_dest` equals `dec_src_b`, a stall is signalled.
- R4: During a stall both `pc_write_en` and `fd_write_en` are 0. Outside a stall both are 1, and the two are always equal.
- R5: `ex_bubble` is 1 exactly when a stall is signalled, so it is always the inverse of `pc_write_en`.
- R6: A load whose `ex_dest` matches neither decoder field causes no stall.
- R7: In a running pipeline, a load followed at once by a dependent instruction stalls for exactly one cycle. The cycle after the stall has no stall, and the dependent instruction then enters execute behind one bubble.
- R8: Two loads in a row where the second does not read the first one's destination cause no stall.
- R9: Register index 0 gets no special treatment: a load into register 0 followed by a reader of register 0 still stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_is_load | input | 1 | Execute-stage instruction reads data memory |
| ex_dest | input | REG_W | Execute-stage second register field (load destination) |
| dec_src_a | input | REG_W | Decode-stage first source register field |
| dec_src_b | input | REG_W | Decode-stage second source register field |
| pc_write_en | output | 1 | Program counter may advance |
| fd_write_en | output | 1 | Fetch/decode register may load |
| ex_bubble | output | 1 | Force zero control into the decode/execute register |

## Verification
The assertions check on every evaluation that the stall is raised for a load matching either source field, that it is never raised without a load and a match, and that the two write enables and the bubble always agree. Only the bench's pipeline scenario can show the timing across cycles. That scenario confirms a dependent instruction is held for exactly one cycle, that it then enters execute behind a bubble, and that independent back-to-back loads and arithmetic producers flow through without stalls. An exhaustive sweep of all field combinations covers the register-0 case and every equality pattern.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int unsigned NUM_SRC    = 2;
  localparam int unsigned SRC_A_IDX  = 0;
  localparam int unsigned SRC_B_IDX  = 1;

  function automatic logic any_hit(input logic [NUM_SRC-1:0] hits);
    return |hits;
  endfunction
endpackage

// File: rtl/lu_operand_cmp.sv
module lu_operand_cmp #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [REG_W-1:0]         dest,
  input  logic [NUM_SRC*REG_W-1:0] srcs,
  output logic [NUM_SRC-1:0]       hits
);
  function automatic logic same_reg(input logic [REG_W-1:0] a,
                                    input logic [REG_W-1:0] b);
    return (a == b);
  endfunction

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign hits[i] = same_reg(dest, srcs[i*REG_W +: REG_W]);
  end
endmodule

// File: rtl/lu_stall_gen.sv
module lu_stall_gen
  import lu_pkg::*;
(
  input  logic               is_load,
  input  logic [NUM_SRC-1:0] hits,
  output logic               hazard,
  output logic               pc_we,
  output logic               fd_we,
  output logic               bubble
);
  always_comb begin
    hazard = is_load && any_hit(hits);
    pc_we  = !hazard;
    fd_we  = !hazard;
    bubble = hazard;
  end
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
  import lu_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] ex_dest,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  output logic             pc_write_en,
  output logic             fd_write_en,
  output logic             ex_bubble
);
  localparam int unsigned SRC_BITS = NUM_SRC * REG_W;

  logic [SRC_BITS-1:0] src_flat;
  logic [NUM_SRC-1:0]  match_vec;
  logic                hazard_evt;

  always_comb begin
    src_flat = '0;
    src_flat[SRC_A_IDX*REG_W +: REG_W] = dec_src_a;
    src_flat[SRC_B_IDX*REG_W +: REG_W] = dec_src_b;
  end

  lu_operand_cmp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_cmp (
    .dest (ex_dest),
    .srcs (src_flat),
    .hits (match_vec)
  );

  lu_stall_gen u_gen (
    .is_load (ex_is_load),
    .hits    (match_vec),
    .hazard  (hazard_evt),
    .pc_we   (pc_write_en),
    .fd_we   (fd_write_en),
    .bubble  (ex_bubble)
  );

  always_comb begin
    if (!ex_is_load)
      assert_no_load_no_stall_R1: assert (!ex_bubble && pc_write_en);
    if (ex_is_load && ex_dest == dec_src_a)
      assert_src_a_stall_R2: assert (ex_bubble);
    if (ex_is_load && ex_dest == dec_src_b)
      assert_src_b_stall_R3: assert (ex_bubble);
    assert_enables_agree_R4: assert (pc_write_en == fd_write_en);
    assert_bubble_inverse_R5: assert (ex_bubble == !pc_write_en);
    if (ex_bubble)
      assert_no_false_stall_R6: assert (ex_is_load &&
        (ex_dest == dec_src_a || ex_dest == dec_src_b));
    if (hazard_evt)
      assert_hazard_holds_front_R4: assert (!fd_write_en);
  end
endmodule

// File: tb/tb_load_use_stall.sv
module tb_load_use_stall;
  localparam int W = 5;

  typedef struct packed {
    logic         ld;
    logic [W-1:0] rs;
    logic [W-1:0] rt;
  } instr_t;

  logic clk = 0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic         use_pipe = 0;
  logic         prst     = 1;
  logic         s_ld;
  logic [W-1:0] s_dest, s_a, s_b;

  instr_t imem [16];
  instr_t fd_q, ex_q;
  logic [3:0] pc;

  logic pc_we, fd_we, bub;

  load_use_stall #(.REG_W(W)) dut (
    .ex_is_load  (use_pipe ? ex_q.ld : s_ld),
    .ex_dest     (use_pipe ? ex_q.rt : s_dest),
    .dec_src_a   (use_pipe ? fd_q.rs : s_a),
    .dec_src_b   (use_pipe ? fd_q.rt : s_b),
    .pc_write_en (pc_we),
    .fd_write_en (fd_we),
    .ex_bubble   (bub)
  );

  always_ff @(posedge clk) begin
    if (prst) begin
      pc   <= '0;
      fd_q <= '0;
      ex_q <= '0;
    end else begin
      if (fd_we) fd_q <= imem[pc];
      if (pc_we) pc <= pc + 4'd1;
      ex_q <= bub ? instr_t'('0) : fd_q;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) imem[i] = '0;
    imem[0] = '{ld:1'b1, rs:5'd0, rt:5'd1};
    imem[1] = '{ld:1'b0, rs:5'd1, rt:5'd2};
    imem[2] = '{ld:1'b1, rs:5'd0, rt:5'd3};
    imem[3] = '{ld:1'b1, rs:5'd5, rt:5'd4};
    imem[4] = '{ld:1'b0, rs:5'd6, rt:5'd4};
    imem[5] = '{ld:1'b0, rs:5'd7, rt:5'd7};
    imem[6] = '{ld:1'b0, rs:5'd7, rt:5'd8};
    s_ld = 0; s_dest = '0; s_a = '0; s_b = '0;

    // reset state: empty pipeline, nothing stalls
    @(posedge clk); @(posedge clk);
    #5;
    chk("R1 reset", int'(bub), 0);
    chk("R4 reset", int'(pc_we), 1);

    // exhaustive sweep
    for (int ld = 0; ld < 2; ld++)
      for (int d = 0; d < 32; d++)
        for (int a = 0; a < 32; a++)
          for (int b = 0; b < 32; b++) begin
            int exp_stall;
            string tag;
            @(posedge clk);
            s_ld = ld[0]; s_dest = d[W-1:0]; s_a = a[W-1:0]; s_b = b[W-1:0];
            exp_stall = (ld != 0 && ((d ^ a) == 0 || (d - b) == 0)) ? 1 : 0;
            if (ld == 0)            tag = "R1";
            else if (d == 0 && exp_stall == 1) tag = "R9";
            else if (d == a)        tag = "R2";
            else if (d == b)        tag = "R3";
            else                    tag = "R6";
            #5;
            chk(tag, int'(bub), exp_stall);
            chk("R4", int'(pc_we) + int'(fd_we), 2 * (1 - exp_stall));
            chk("R5", int'(bub), 1 - int'(pc_we));
          end

    // pipeline scenario
    @(negedge clk);
    use_pipe = 1; prst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    prst = 0;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk);
      #5;
      if (k == 2 || k == 6)
        chk(k == 2 ? "R7 stall on dependent rs" : "R7 stall on dependent rt", int'(bub), 1);
      else if (k == 5)
        chk("R8 back-to-back loads", int'(bub), 0);
      else if (k == 9)
        chk("R1 arithmetic producer", int'(bub), 0);
      else
        chk("R7 no extra stall", int'(bub), 0);
      if (k == 3) begin
        chk("R4 decode held", int'(fd_q), int'(imem[1]));
        chk("R5 bubble in execute", int'(ex_q), 0);
        chk("R4 pc held", int'(pc), 2);
      end
      if (k == 4)
        chk("R7 consumer enters execute", int'(ex_q), int'(imem[1]));
      if (k == 8)
        chk("R7 second consumer enters execute", int'(ex_q), int'(imem[4]));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule